// File: doc/BRIEF.md
# ADC Readout Standby Controller

This block is the digital serial side of a 24-bit delta-sigma converter. When the converter hands over a finished result with a one-cycle strobe, the block pulls its combined ready/data line low. The host then clocks the word out on an external serial clock, most significant bit first. A fresh bit appears on each rising serial-clock edge, and the line returns high after the last bit has been taken.

The host can also park the converter. It does this by holding the serial clock high while a result is pending or partly read. Once the clock has stayed high for an activation window, the block enters standby. The activation window is a cycle count picked by the speed select. In standby the ready/data line is forced high, a status flag is raised and the analog enable is dropped, while the system clock domain keeps running.

Pulling the serial clock low ends standby. A wake-up window then starts, also set by the speed select. During this window the line stays high and any arriving results are held back. When the window closes, the most recent result captured during it is flagged as ready, and that result is valid. The serial clock is resynchronised through a flop chain before any edge detection or level timing.

Top module: `adc_standby_ctrl`

## Requirements
- R1: After reset, drdy_dout is 1, standby_o is 0 and analog_en is 1.
- R2: A res_vld pulse while no standby or wake-up is in progress loads res_data and drives drdy_dout to 0 on the following clock. A pulse arriving mid-readout discards the old word and restarts the readout from the new word's bit 23.
- R3: Each rising serial-clock edge after ready puts the next data bit on drdy_dout, starting at bit 23 and ending at bit 0. The line changes three system clocks after sclk_in rises: two synchroniser stages plus one register.
- R4: On the falling serial-clock edge after bit 0 has been presented, drdy_dout returns to 1.
- R5: While a result is pending or being read, standby_o rises once the synchronised serial clock has been high for a run of consecutive clocks. The run is ACT_FAST clocks with speed_sel=1 and ACT_SLOW clocks with speed_sel=0. Counted from the cycle sclk_in is raised, standby_o is still 0 after ACT+1 clock edges and is 1 after ACT+2 edges.
- R6: A high run one clock shorter than the activation count does not enter standby. A serial clock held high while no result is pending never enters standby.
- R7: In standby, drdy_dout is 1 and analog_en is 0, and res_vld pulses have no effect.
- R8: When sclk_in goes low in standby, standby_o falls three clock edges later. drdy_dout then stays 1 for a wake-up window of WAKE_FAST clocks (speed_sel=1) or WAKE_SLOW clocks (speed_sel=0).
- R9: When the wake-up window ends, the last word strobed during it is presented: drdy_dout goes to 0 and that word reads out normally. If no word arrived during the window, the line stays 1 and the block waits for the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_sel | input | 1 | 1 selects the fast timing set, 0 the slow one |
| sclk_in | input | 1 | External serial clock from the host, asynchronous |
| res_data | input | DATA_W | Conversion result |
| res_vld | input | 1 | One-cycle strobe marking res_data valid |
| drdy_dout | output | 1 | Combined ready (low) and serial data line |
| standby_o | output | 1 | High while in standby |
| analog_en | output | 1 | Enable for the analog section, low in standby |

## Verification
Some properties are checked on every cycle. The line must be high whenever standby is flagged. Standby may only start after the raw serial clock has been high for at least the activation count. Standby may only end after the raw clock was seen low. The line must stay high for the whole wake-up window, which is tracked with a counter in the checker. Other behaviour is shown only by the bench scenarios: the MSB-first bit order, the return to high after bit 0, replacing a word mid-readout, the exact boundary one clock short of activation, standby with a partly read word, and which word is presented after wake-up.

// File: rtl/adc_sb_pkg.sv
package adc_sb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_STBY  = 2'd2,
        ST_WAKE  = 2'd3
    } rd_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_sclk_sync.sv
module adc_sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    output logic sclk_lvl,
    output logic sclk_rise,
    output logic sclk_fall
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], sclk_in};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sclk_lvl  = s_q.chain[STAGES-1];
    assign sclk_rise = s_q.chain[STAGES-1] & ~s_q.prev;
    assign sclk_fall = ~s_q.chain[STAGES-1] & s_q.prev;
endmodule

// File: rtl/adc_run_timer.sv
module adc_run_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run || clr) cnt_d = '0;
        else             cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = run && !clr && (cnt_q == limit - W'(1));
endmodule

// File: rtl/adc_standby_ctrl.sv
module adc_standby_ctrl
    import adc_sb_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int ACT_FAST    = 61243,
    parameter int ACT_SLOW    = 491324,
    parameter int WAKE_FAST   = 258097,
    parameter int WAKE_SLOW   = 1974927,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              speed_sel,
    input  logic              sclk_in,
    input  logic [DATA_W-1:0] res_data,
    input  logic              res_vld,
    output logic              drdy_dout,
    output logic              standby_o,
    output logic              analog_en
);
    localparam int MAX_T = max2(max2(ACT_FAST, ACT_SLOW), max2(WAKE_FAST, WAKE_SLOW));
    localparam int CNT_W = $clog2(MAX_T + 1);
    localparam int BIT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        rd_state_e         st;
        logic [DATA_W-1:0] shreg;
        logic [BIT_W-1:0]  nbits;
        logic              line;
        logic              pend_vld;
        logic [DATA_W-1:0] pend;
    } core_t;

    core_t c_d, c_q;

    logic sclk_lvl, sclk_rise, sclk_fall;
    logic hold_done, wake_done, hold_clr;
    logic [CNT_W-1:0] act_lim, wake_lim;

    adc_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_in  (sclk_in),
        .sclk_lvl (sclk_lvl),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall)
    );

    assign act_lim  = speed_sel ? CNT_W'(ACT_FAST)  : CNT_W'(ACT_SLOW);
    assign wake_lim = speed_sel ? CNT_W'(WAKE_FAST) : CNT_W'(WAKE_SLOW);
    assign hold_clr = res_vld;

    adc_run_timer #(.W(CNT_W)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .run  ((c_q.st == ST_READY) && sclk_lvl),
        .clr  (hold_clr),
        .limit(act_lim),
        .done (hold_done)
    );

    adc_run_timer #(.W(CNT_W)) u_wake (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (c_q.st == ST_WAKE),
        .clr  (1'b0),
        .limit(wake_lim),
        .done (wake_done)
    );

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            ST_IDLE: begin
                c_d.line = 1'b1;
                if (res_vld) begin
                    c_d.st    = ST_READY;
                    c_d.shreg = res_data;
                    c_d.nbits = '0;
                    c_d.line  = 1'b0;
                end
            end
            ST_READY: begin
                if (res_vld) begin
                    c_d.shreg = res_data;
                    c_d.nbits = '0;
                    c_d.line  = 1'b0;
                end else if (hold_done) begin
                    c_d.st   = ST_STBY;
                    c_d.line = 1'b1;
                end else if (sclk_rise && (c_q.nbits < BIT_W'(DATA_W))) begin
                    c_d.line  = c_q.shreg[DATA_W-1];
                    c_d.shreg = {c_q.shreg[DATA_W-2:0], 1'b0};
                    c_d.nbits = c_q.nbits + BIT_W'(1);
                end else if (sclk_fall && (c_q.nbits == BIT_W'(DATA_W))) begin
                    c_d.st   = ST_IDLE;
                    c_d.line = 1'b1;
                end
            end
            ST_STBY: begin
                c_d.line = 1'b1;
                if (!sclk_lvl) begin
                    c_d.st       = ST_WAKE;
                    c_d.pend_vld = 1'b0;
                end
            end
            ST_WAKE: begin
                c_d.line = 1'b1;
                if (res_vld) begin
                    c_d.pend     = res_data;
                    c_d.pend_vld = 1'b1;
                end
                if (wake_done) begin
                    if (res_vld || c_q.pend_vld) begin
                        c_d.st    = ST_READY;
                        c_d.shreg = res_vld ? res_data : c_q.pend;
                        c_d.nbits = '0;
                        c_d.line  = 1'b0;
                    end else begin
                        c_d.st = ST_IDLE;
                    end
                    c_d.pend_vld = 1'b0;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.st   <= ST_IDLE;
            c_q.line <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign drdy_dout = c_q.line;
    assign standby_o = (c_q.st == ST_STBY);
    assign analog_en = (c_q.st != ST_STBY);
endmodule

// File: rtl/adc_standby_ctrl_chk.sv
module adc_standby_ctrl_chk #(
    parameter int ACT_FAST  = 4,
    parameter int ACT_SLOW  = 8,
    parameter int WAKE_FAST = 4,
    parameter int WAKE_SLOW = 8
) (
    input logic clk,
    input logic rst_n,
    input logic speed_sel,
    input logic sclk_in,
    input logic drdy_dout,
    input logic standby_o
);
    logic [31:0] hi_run_q;
    logic [31:0] wk_left_q;
    logic        stby_p_q;
    logic        fall_now;

    assign fall_now = stby_p_q && !standby_o;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run_q  <= '0;
            wk_left_q <= '0;
            stby_p_q  <= 1'b0;
        end else begin
            stby_p_q <= standby_o;
            if (!sclk_in)                 hi_run_q <= '0;
            else if (hi_run_q != '1)      hi_run_q <= hi_run_q + 32'd1;
            if (fall_now)                 wk_left_q <= (speed_sel ? 32'(WAKE_FAST) : 32'(WAKE_SLOW)) - 32'd1;
            else if (wk_left_q != '0)     wk_left_q <= wk_left_q - 32'd1;
        end
    end

    // R7: line parked high during standby
    a_r7_line_high_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o |-> drdy_dout);

    // R5: no entry before a full activation run of the raw clock
    a_r5_min_high_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(standby_o) |-> (hi_run_q >= (speed_sel ? 32'(ACT_FAST) : 32'(ACT_SLOW))));

    // R5: entry only with the serial clock still high
    a_r5_entry_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(standby_o) |-> $past(sclk_in, 2));

    // R8: exit only after the serial clock was low
    a_r8_exit_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(standby_o) |-> !$past(sclk_in, 2));

    // R8: line high across the whole wake-up window
    a_r8_wake_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_now || (wk_left_q != '0)) |-> drdy_dout);
endmodule

bind adc_standby_ctrl adc_standby_ctrl_chk #(
    .ACT_FAST (ACT_FAST),
    .ACT_SLOW (ACT_SLOW),
    .WAKE_FAST(WAKE_FAST),
    .WAKE_SLOW(WAKE_SLOW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .speed_sel(speed_sel),
    .sclk_in  (sclk_in),
    .drdy_dout(drdy_dout),
    .standby_o(standby_o)
);

// File: tb/sim_adc_standby_ctrl.sv
module sim_adc_standby_ctrl;
    localparam int DW  = 24;
    localparam int AF  = 20;
    localparam int AS  = 40;
    localparam int WF  = 30;
    localparam int WS  = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spd = 1'b1;
    logic sclk = 1'b0;
    logic [DW-1:0] data = '0;
    logic vld = 1'b0;
    logic line, stby, aen;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    adc_standby_ctrl #(
        .DATA_W(DW), .ACT_FAST(AF), .ACT_SLOW(AS), .WAKE_FAST(WF), .WAKE_SLOW(WS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .speed_sel(spd), .sclk_in(sclk),
        .res_data(data), .res_vld(vld),
        .drdy_dout(line), .standby_o(stby), .analog_en(aen)
    );

    function automatic logic exp_bit(input logic [DW-1:0] w, input int idx);
        return w[DW-1-idx];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input logic [DW-1:0] w);
        data = w; vld = 1'b1;
        step(1);
        vld = 1'b0;
    endtask

    task automatic read_bits(input logic [DW-1:0] w, input int from, input int upto, input string req);
        for (int i = from; i <= upto; i++) begin
            sclk = 1'b1;
            step(4);
            check(req, 32'(line), 32'(exp_bit(w, i)));
            sclk = 1'b0;
            step(4);
        end
    endtask

    task automatic hold_entry(input int act);
        sclk = 1'b1;
        step(act + 1);
        check("R5 not yet in standby", 32'(stby), 32'd0);
        step(1);
        check("R5 standby entered", 32'(stby), 32'd1);
        check("R7 line high", 32'(line), 32'd1);
        check("R7 analog off", 32'(aen), 32'd0);
    endtask

    task automatic wake_up(input int wk, input bit give, input logic [DW-1:0] w);
        sclk = 1'b0;
        step(2);
        check("R8 still in standby", 32'(stby), 32'd1);
        step(1);
        check("R8 standby left", 32'(stby), 32'd0);
        check("R8 analog on", 32'(aen), 32'd1);
        if (give) begin
            step(3);
            strobe(w);
            step(wk + 2 - 7);
            check("R8 line high to window end", 32'(line), 32'd1);
            step(1);
            check("R9 ready after window", 32'(line), 32'd0);
        end else begin
            step(wk + 4);
            check("R9 idle after empty window", 32'(line), 32'd1);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] w, w2, wx;
        int k;
        void'($urandom(32'd4242));
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R1 line", 32'(line), 32'd1);
        check("R1 standby", 32'(stby), 32'd0);
        check("R1 analog", 32'(aen), 32'd1);

        // R6: clock held high with nothing pending
        sclk = 1'b1;
        step(AS + 10);
        check("R6 idle hold no standby", 32'(stby), 32'd0);
        check("R6 idle line high", 32'(line), 32'd1);
        sclk = 1'b0;
        step(4);

        for (int n = 0; n < 6; n++) begin
            spd = 1'($urandom % 2);
            w = DW'($urandom);
            strobe(w);
            check("R2 ready low", 32'(line), 32'd0);
            read_bits(w, 0, DW - 1, "R3 bit order");
            check("R4 line back high", 32'(line), 32'd1);
        end

        // R2: replacement mid-readout
        w = DW'($urandom);
        w2 = DW'($urandom);
        strobe(w);
        read_bits(w, 0, 2, "R3 partial");
        strobe(w2);
        check("R2 reload low", 32'(line), 32'd0);
        read_bits(w2, 0, DW - 1, "R2 reloaded word");
        check("R4 high after reload", 32'(line), 32'd1);

        // fast standby partway through a readout
        spd = 1'b1;
        w = DW'($urandom);
        strobe(w);
        k = int'($urandom % 24);
        if (k > 0) read_bits(w, 0, k - 1, "R3 before standby");
        hold_entry(AF);
        wx = DW'($urandom);
        strobe(wx);
        step(3);
        check("R7 strobe ignored line", 32'(line), 32'd1);
        check("R7 strobe ignored standby", 32'(stby), 32'd1);
        w2 = DW'($urandom);
        wake_up(WF, 1'b1, w2);
        read_bits(w2, 0, DW - 1, "R9 word after wake");
        check("R4 high after wake readout", 32'(line), 32'd1);

        // slow: one clock short of activation
        spd = 1'b0;
        w = DW'($urandom);
        strobe(w);
        sclk = 1'b1;
        step(AS - 1);
        sclk = 1'b0;
        step(6);
        check("R6 short run no standby", 32'(stby), 32'd0);
        check("R6 analog stays on", 32'(aen), 32'd1);
        check("R3 first bit after long high", 32'(line), 32'(exp_bit(w, 0)));
        read_bits(w, 1, DW - 1, "R3 rest of word");
        check("R4 high", 32'(line), 32'd1);

        // slow standby with an empty wake-up window
        w = DW'($urandom);
        strobe(w);
        hold_entry(AS);
        wake_up(WS, 1'b0, w);
        check("R9 standby clear", 32'(stby), 32'd0);
        w = DW'($urandom);
        strobe(w);
        check("R2 ready after idle wake", 32'(line), 32'd0);
        read_bits(w, 0, DW - 1, "R3 after idle wake");

        // slow standby with a new word in the window
        w = DW'($urandom);
        strobe(w);
        hold_entry(AS);
        w2 = DW'($urandom);
        wake_up(WS, 1'b1, w2);
        read_bits(w2, 0, DW - 1, "R9 slow wake word");
        check("R4 final high", 32'(line), 32'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule